// File: doc/BRIEF.md
# Prefetch Queue Execution Tracker

This block lets a trace capture unit record a CPU's instruction bytes in the order they execute, not the order the CPU fetched them. A CPU with a prefetch queue reads code ahead of time, so a plain bus trace shows fetches long before the matching bytes run. The tracker watches every bus cycle. Instruction fetches are held back: their bytes go into a local mirror of the CPU's queue. Any other bus cycle goes straight to the trace output, including cycles run by a second bus master such as a coprocessor.

The CPU reports on a 2-bit queue status input when it takes a byte from its own queue. For each such report the tracker removes the oldest mirrored byte and emits it as an executed-byte record. The record carries the address held in a running counter, which then advances by one. A program transfer clears the mirror and loads the counter with the target address. Status code 10 also clears the mirror, but leaves the counter alone.

All records leave on a single registered trace port. The port is driven by a small arbitration state machine with four states: ARB_IDLE, ARB_EXEC, ARB_BUS and ARB_EXEC_DROP. From any state the next state is chosen from the current cycle's requests. Both requests select ARB_EXEC_DROP. An executed byte alone selects ARB_EXEC. A non-fetch bus cycle alone selects ARB_BUS. No request selects ARB_IDLE.

Top module: `pfq_trace_tracker`

## Requirements
- R1: A synchronous reset clears all state. After reset, trc_valid, trc_type, trc_addr, trc_data, trc_lost, err_underflow and err_overflow all read 0.
- R2: A bus cycle with bus_valid=1 and bus_fetch=0 appears on the trace port one clock later with trc_valid=1, trc_type=0, trc_lost=0, and the cycle's own address and data, unless an executed byte is emitted in the same cycle.
- R3: A fetch cycle (bus_valid=1, bus_fetch=1) produces no trace record. On the 16-bit bus variant, an even fetch address pushes bus_data[7:0] and then bus_data[15:8]. An odd fetch address pushes only bus_data[15:8].
- R4: Queue status 01 (first opcode byte) or 11 (later byte) removes the oldest mirrored byte. One clock later it appears with trc_type=1 and trc_data = {8'h00, byte}.
- R5: Each executed-byte record carries the current counter address, and the counter then advances by one.
- R6: A program transfer (xfer_valid=1) clears the mirror and loads the counter with xfer_target. A byte popped in the same cycle is still emitted, at the old address. A fetch in the same cycle is discarded.
- R7: Queue status 10 clears the mirror without changing the counter. A fetch in the same cycle is discarded.
- R8: When an executed byte and a non-fetch bus cycle arrive in the same cycle, only the executed byte is emitted, and it carries trc_lost=1.
- R9: A pop request while the mirror is empty emits nothing and sets err_underflow, which stays set until reset.
- R10: A fetch whose bytes would not fit after this cycle's pop is rejected as a whole, leaving the mirror contents unchanged, and sets err_overflow, which stays set until reset. The default depth is 6 bytes (4 on the 8-bit variant).
- R11: A cycle with no bus cycle and queue status 00 produces no trace record one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | A bus cycle completes this clock |
| bus_fetch | input | 1 | 1 = the cycle is an instruction fetch |
| bus_addr | input | AW | Bus cycle address |
| bus_data | input | 16 | Bus cycle data (8-bit variant uses [7:0]) |
| qs | input | 2 | CPU queue status: 00 none, 01 first byte, 10 flush, 11 later byte |
| xfer_valid | input | 1 | Program transfer detected |
| xfer_target | input | AW | Target address of the transfer |
| trc_valid | output | 1 | Trace record present |
| trc_type | output | 1 | 1 = executed byte, 0 = bus operation |
| trc_addr | output | AW | Record address |
| trc_data | output | 16 | Record data |
| trc_lost | output | 1 | A bus record was dropped for this record |
| err_underflow | output | 1 | Sticky: pop from an empty mirror |
| err_overflow | output | 1 | Sticky: fetch rejected for lack of room |

## Verification
A mirror pointer or count that drifts from the CPU's real queue shows up on the next pop. The byte on trc_data is then wrong, or an underflow flag appears, one clock after the queue status reports a byte taken. A counter fault shows as a wrong trc_addr on the very next executed-byte record. An arbitration fault shows within one clock of a conflict: either two records for one cycle, or a record with trc_lost clear. The bench therefore models the mirror and the counter itself and compares every emitted record in order.

// File: rtl/pfq_trace_pkg.sv
package pfq_trace_pkg;

    // CPU queue status encoding
    typedef enum logic [1:0] {
        QS_IDLE  = 2'b00,
        QS_FIRST = 2'b01,
        QS_FLUSH = 2'b10,
        QS_NEXT  = 2'b11
    } qstat_e;

    // trace port arbitration: which record is held on the output
    typedef enum logic [1:0] {
        ARB_IDLE      = 2'b00,
        ARB_EXEC      = 2'b01,
        ARB_BUS       = 2'b10,
        ARB_EXEC_DROP = 2'b11
    } arb_e;

endpackage

// File: rtl/pfq_fetch_unpack.sv
module pfq_fetch_unpack #(
    parameter int WIDE_BUS = 1
) (
    input  logic        fetch,
    input  logic        addr_lsb,
    input  logic [15:0] data,
    output logic [1:0]  n_bytes,
    output logic [7:0]  byte0,
    output logic [7:0]  byte1
);
    generate
        if (WIDE_BUS != 0) begin : g_wide
            always_comb begin
                if (!fetch) begin
                    n_bytes = 2'd0;
                    byte0   = 8'h00;
                    byte1   = 8'h00;
                end else if (addr_lsb) begin
                    n_bytes = 2'd1;
                    byte0   = data[15:8];
                    byte1   = 8'h00;
                end else begin
                    n_bytes = 2'd2;
                    byte0   = data[7:0];
                    byte1   = data[15:8];
                end
            end
        end else begin : g_narrow
            logic unused_bits;
            assign unused_bits = addr_lsb ^ (^data[15:8]);
            always_comb begin
                n_bytes = fetch ? 2'd1 : 2'd0;
                byte0   = fetch ? data[7:0] : 8'h00;
                byte1   = 8'h00;
            end
        end
    endgenerate
endmodule

// File: rtl/pfq_mirror_fifo.sv
module pfq_mirror_fifo #(
    parameter int DEPTH = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic [1:0] push_n,
    input  logic [7:0] push_b0,
    input  logic [7:0] push_b1,
    input  logic       pop,
    output logic       pop_ok,
    output logic [7:0] pop_byte,
    output logic       ovf,
    output logic       unf
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] after_pop;
    logic [CW:0]   need;
    logic          push_req, fits, push_ok, push_rej;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        pop_ok    = pop && (cnt_q != '0);
        pop_byte  = mem[rd_q];
        after_pop = cnt_q - CW'(pop_ok);
        need      = {1'b0, after_pop} + (CW+1)'(push_n);
        fits      = (need <= (CW+1)'(DEPTH));
        push_req  = (push_n != 2'd0) && !clear;
        push_ok   = push_req && fits;
        push_rej  = push_req && !fits;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
            ovf   <= 1'b0;
            unf   <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else begin
            if (pop && (cnt_q == '0)) unf <= 1'b1;
            if (push_rej)             ovf <= 1'b1;
            if (clear) begin
                rd_q  <= '0;
                wr_q  <= '0;
                cnt_q <= '0;
            end else begin
                if (pop_ok) rd_q <= step(rd_q);
                if (push_ok) begin
                    mem[wr_q] <= push_b0;
                    if (push_n == 2'd2) begin
                        mem[step(wr_q)] <= push_b1;
                        wr_q <= step(step(wr_q));
                    end else begin
                        wr_q <= step(wr_q);
                    end
                    cnt_q <= CW'(need);
                end else begin
                    cnt_q <= after_pop;
                end
            end
        end
    end
endmodule

// File: rtl/pfq_addr_ctr.sv
module pfq_addr_ctr #(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          advance,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    output logic [AW-1:0] addr
);
    always_ff @(posedge clk) begin
        if (rst)          addr <= '0;
        else if (load)    addr <= load_val;
        else if (advance) addr <= addr + 1'b1;
    end
endmodule

// File: rtl/pfq_trace_arb.sv
module pfq_trace_arb
    import pfq_trace_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          exec_req,
    input  logic [AW-1:0] exec_addr,
    input  logic [7:0]    exec_byte,
    input  logic          bus_req,
    input  logic [AW-1:0] bus_addr,
    input  logic [15:0]   bus_data,
    output logic          trc_valid,
    output logic          trc_type,
    output logic [AW-1:0] trc_addr,
    output logic [15:0]   trc_data,
    output logic          trc_lost
);
    arb_e          state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [15:0]   data_q;

    // next-state selection: executed bytes always win
    always_comb begin
        unique case ({exec_req, bus_req})
            2'b11:   state_d = ARB_EXEC_DROP;
            2'b10:   state_d = ARB_EXEC;
            2'b01:   state_d = ARB_BUS;
            default: state_d = ARB_IDLE;
        endcase
    end

    // state register and record payload
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ARB_IDLE;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (exec_req) begin
                addr_q <= exec_addr;
                data_q <= {8'h00, exec_byte};
            end else if (bus_req) begin
                addr_q <= bus_addr;
                data_q <= bus_data;
            end
        end
    end

    // outputs decoded from the held state
    always_comb begin
        trc_addr = addr_q;
        trc_data = data_q;
        unique case (state_q)
            ARB_IDLE:      begin trc_valid = 1'b0; trc_type = 1'b0; trc_lost = 1'b0; end
            ARB_EXEC:      begin trc_valid = 1'b1; trc_type = 1'b1; trc_lost = 1'b0; end
            ARB_BUS:       begin trc_valid = 1'b1; trc_type = 1'b0; trc_lost = 1'b0; end
            ARB_EXEC_DROP: begin trc_valid = 1'b1; trc_type = 1'b1; trc_lost = 1'b1; end
            default:       begin trc_valid = 1'b0; trc_type = 1'b0; trc_lost = 1'b0; end
        endcase
    end
endmodule

// File: rtl/pfq_trace_tracker.sv
module pfq_trace_tracker
    import pfq_trace_pkg::*;
#(
    parameter int WIDE_BUS = 1,
    parameter int AW       = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_valid,
    input  logic          bus_fetch,
    input  logic [AW-1:0] bus_addr,
    input  logic [15:0]   bus_data,
    input  logic [1:0]    qs,
    input  logic          xfer_valid,
    input  logic [AW-1:0] xfer_target,
    output logic          trc_valid,
    output logic          trc_type,
    output logic [AW-1:0] trc_addr,
    output logic [15:0]   trc_data,
    output logic          trc_lost,
    output logic          err_underflow,
    output logic          err_overflow
);
    localparam int DEPTH = (WIDE_BUS != 0) ? 6 : 4;

    qstat_e        qs_e;
    logic          is_fetch, is_other, pop_req, mirror_clear;
    logic [1:0]    push_n;
    logic [7:0]    push_b0, push_b1, pop_byte;
    logic          pop_ok;
    logic [AW-1:0] pc_addr;

    always_comb begin
        qs_e         = qstat_e'(qs);
        is_fetch     = bus_valid && bus_fetch;
        is_other     = bus_valid && !bus_fetch;
        pop_req      = (qs_e == QS_FIRST) || (qs_e == QS_NEXT);
        mirror_clear = xfer_valid || (qs_e == QS_FLUSH);
    end

    pfq_fetch_unpack #(.WIDE_BUS(WIDE_BUS)) u_unpack (
        .fetch    (is_fetch),
        .addr_lsb (bus_addr[0]),
        .data     (bus_data),
        .n_bytes  (push_n),
        .byte0    (push_b0),
        .byte1    (push_b1)
    );

    pfq_mirror_fifo #(.DEPTH(DEPTH)) u_mirror (
        .clk      (clk),
        .rst      (rst),
        .clear    (mirror_clear),
        .push_n   (push_n),
        .push_b0  (push_b0),
        .push_b1  (push_b1),
        .pop      (pop_req),
        .pop_ok   (pop_ok),
        .pop_byte (pop_byte),
        .ovf      (err_overflow),
        .unf      (err_underflow)
    );

    pfq_addr_ctr #(.AW(AW)) u_pc (
        .clk      (clk),
        .rst      (rst),
        .advance  (pop_ok),
        .load     (xfer_valid),
        .load_val (xfer_target),
        .addr     (pc_addr)
    );

    pfq_trace_arb #(.AW(AW)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .exec_req  (pop_ok),
        .exec_addr (pc_addr),
        .exec_byte (pop_byte),
        .bus_req   (is_other),
        .bus_addr  (bus_addr),
        .bus_data  (bus_data),
        .trc_valid (trc_valid),
        .trc_type  (trc_type),
        .trc_addr  (trc_addr),
        .trc_data  (trc_data),
        .trc_lost  (trc_lost)
    );
endmodule

// File: rtl/pfq_trace_chk.sv
module pfq_trace_chk #(
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_valid,
    input logic          bus_fetch,
    input logic [AW-1:0] bus_addr,
    input logic [15:0]   bus_data,
    input logic [1:0]    qs,
    input logic          trc_valid,
    input logic          trc_type,
    input logic [AW-1:0] trc_addr,
    input logic [15:0]   trc_data,
    input logic          trc_lost,
    input logic          err_underflow,
    input logic          err_overflow
);
    AST_BUS_ECHO: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_fetch && !qs[0]) |=> (trc_valid && !trc_type && trc_addr == $past(bus_addr) && trc_data == $past(bus_data))); // R2
    AST_FETCH_SILENT: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_fetch && !qs[0]) |=> !trc_valid); // R3
    AST_EXEC_NEEDS_POP: assert property (@(posedge clk) disable iff (rst)
        (trc_valid && trc_type) |-> $past(qs[0])); // R4
    AST_EXEC_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
        (trc_valid && trc_type) |-> (trc_data[15:8] == 8'h00)); // R4
    AST_LOST_ON_EXEC: assert property (@(posedge clk) disable iff (rst)
        trc_lost |-> (trc_valid && trc_type)); // R8
    AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_underflow |=> err_underflow); // R9
    AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_overflow |=> err_overflow); // R10
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (!bus_valid && !qs[0]) |=> !trc_valid); // R11
endmodule

bind pfq_trace_tracker pfq_trace_chk #(.AW(AW)) i_chk (.*);

// File: tb/test_pfq_trace_tracker.sv
module test_pfq_trace_tracker;
    localparam int AW    = 20;
    localparam int DEPTH = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_valid = 1'b0, bus_fetch = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [15:0]   bus_data = '0;
    logic [1:0]    qs = 2'b00;
    logic          xfer_valid = 1'b0;
    logic [AW-1:0] xfer_target = '0;
    logic          trc_valid, trc_type, trc_lost, err_underflow, err_overflow;
    logic [AW-1:0] trc_addr;
    logic [15:0]   trc_data;

    int checks = 0;
    int failures = 0;

    // scoreboard: {type, lost, addr, data}
    logic [AW+17:0] exp_rec[$];
    string          exp_tag[$];
    logic [7:0]     mq[$];
    logic [AW-1:0]  mc = '0;

    always #2 clk = ~clk;

    pfq_trace_tracker #(.WIDE_BUS(1), .AW(AW)) i_pfq_trace_tracker (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic cyc(input bit bv, input bit bf, input logic [AW-1:0] ba, input logic [15:0] bd,
                       input logic [1:0] q, input bit xv, input logic [AW-1:0] xt, input string tag);
        bit popped;
        logic [7:0] b;
        int n;
        @(negedge clk);
        bus_valid = bv; bus_fetch = bf; bus_addr = ba; bus_data = bd;
        qs = q; xfer_valid = xv; xfer_target = xt;
        popped = 0;
        if (q[0] && mq.size() != 0) begin
            b = mq.pop_front();
            popped = 1;
            exp_rec.push_back({1'b1, (bv && !bf), mc, 8'h00, b});
            exp_tag.push_back(tag);
            mc = mc + 1'b1;
        end
        if (bv && !bf && !popped) begin
            exp_rec.push_back({1'b0, 1'b0, ba, bd});
            exp_tag.push_back(tag);
        end
        if (bv && bf && !xv && q != 2'b10) begin
            n = ba[0] ? 1 : 2;
            if (mq.size() + n <= DEPTH) begin
                if (ba[0]) mq.push_back(bd[15:8]);
                else begin mq.push_back(bd[7:0]); mq.push_back(bd[15:8]); end
            end
        end
        if (xv) begin mq.delete(); mc = xt; end
        if (q == 2'b10) mq.delete();
    endtask

    task automatic idle();
        cyc(0, 0, '0, '0, 2'b00, 0, '0, "R11");
    endtask

    // monitor: compare every emitted record against the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst && trc_valid) begin
                if (exp_rec.size() == 0) begin
                    checks++; failures++;
                    $display("FAIL R11 unexpected record actual=%0h expected=none",
                             {trc_type, trc_lost, trc_addr, trc_data});
                end else begin
                    logic [AW+17:0] e;
                    string t;
                    e = exp_rec.pop_front();
                    t = exp_tag.pop_front();
                    chk(t, 64'({trc_type, trc_lost, trc_addr, trc_data}), 64'(e));
                end
            end
        end
    end

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", 64'(trc_valid), 0);
        chk("R1", 64'({trc_type, trc_lost, trc_addr, trc_data}), 0);
        chk("R1", 64'({err_underflow, err_overflow}), 0);
        rst = 1'b0;

        cyc(1, 0, 20'h12345, 16'hBEEF, 2'b00, 0, '0, "R2");
        cyc(0, 0, '0, '0, 2'b00, 1, 20'h01000, "R6");
        cyc(1, 1, 20'h01000, 16'h2211, 2'b00, 0, '0, "R3");
        cyc(1, 1, 20'h01003, 16'h4433, 2'b00, 0, '0, "R3");
        idle();
        chk("R3", 64'(trc_valid), 0);
        cyc(0, 0, '0, '0, 2'b01, 0, '0, "R4");
        cyc(0, 0, '0, '0, 2'b11, 0, '0, "R5");
        idle();
        idle();
        chk("R11", 64'(trc_valid), 0);
        cyc(0, 0, '0, '0, 2'b11, 0, '0, "R5");

        // R9 pop from empty mirror
        cyc(0, 0, '0, '0, 2'b01, 0, '0, "R9");
        idle();
        chk("R9", 64'(trc_valid), 0);
        chk("R9", 64'(err_underflow), 1);

        // R10 fill, then overflow
        cyc(1, 1, 20'h02000, 16'hB1A1, 2'b00, 0, '0, "R10");
        cyc(1, 1, 20'h02002, 16'hB2A2, 2'b00, 0, '0, "R10");
        cyc(1, 1, 20'h02004, 16'hB3A3, 2'b00, 0, '0, "R10");
        idle();
        chk("R10", 64'(err_overflow), 0);
        cyc(1, 1, 20'h02006, 16'hB4A4, 2'b00, 0, '0, "R10");
        idle();
        chk("R10", 64'(err_overflow), 1);
        for (int i = 0; i < DEPTH; i++) cyc(0, 0, '0, '0, 2'b11, 0, '0, "R10");

        // R8 conflict
        cyc(1, 1, 20'h03000, 16'h5150, 2'b00, 0, '0, "R8");
        cyc(1, 0, 20'h0ABCD, 16'h7777, 2'b01, 0, '0, "R8");
        cyc(1, 0, 20'h0ABCE, 16'h6666, 2'b00, 0, '0, "R2");

        // R7 flush by queue status
        cyc(1, 1, 20'h04000, 16'h6160, 2'b00, 0, '0, "R7");
        cyc(0, 0, '0, '0, 2'b10, 0, '0, "R7");
        cyc(1, 1, 20'h04010, 16'h7170, 2'b00, 0, '0, "R7");
        cyc(1, 1, 20'h04020, 16'hEEDD, 2'b10, 0, '0, "R7");
        cyc(1, 1, 20'h04012, 16'h7372, 2'b00, 0, '0, "R7");
        cyc(0, 0, '0, '0, 2'b01, 0, '0, "R7");

        // R6 transfer with same-cycle pop and fetch
        cyc(1, 1, 20'h05000, 16'h8180, 2'b11, 1, 20'h09000, "R6");
        cyc(1, 1, 20'h09001, 16'h9190, 2'b00, 0, '0, "R6");
        cyc(0, 0, '0, '0, 2'b01, 0, '0, "R6");
        repeat (3) idle();

        chk("R4", 64'(exp_rec.size()), 0);
        chk("R9", 64'(err_underflow), 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule